// File: doc/BRIEF.md
# Two-Dimensional 8x8 Inverse DCT Accelerator

This block turns an 8x8 block of frequency-domain coefficients into an 8x8 block of pixel values. The coefficients arrive as eight 128-bit row writes, each word packing eight signed 16-bit values. Every arriving row is transformed at once by a bank of eight multiply-accumulate lanes (the row pass), and the rounded results are kept in a transpose store. When the eighth row is done, the same kind of lane bank runs the column pass across the store and fills an output store. The host then pulls eight 128-bit result rows through a ready/valid handshake.

There is no start command. The first row write starts the work, and the result block follows a fixed number of cycles after the last row is accepted. A read that is attempted before the results exist simply waits on `out_valid`. The input side stays closed from the eighth accepted row until the last result row has been taken, so a new block cannot overwrite one that is still pending.

Top module: `idct8_accel`

## Requirements
- R1: After a cycle with the synchronous active-high `rst` high, `out_valid` is 0 and `wr_ready` is 1.
- R2: A row is taken on a rising edge where `wr_valid` and `wr_ready` are both 1. Value i of a row sits in bits [16i+15:16i] as a signed number with 12 significant bits (-2048..2047). Rows accepted in turn are block rows u = 0..7.
- R3: Row pass: r[u][n] = sat16((S + 1024) >>> 11), where S = sum over k of C(k,n)·X[u][k]. The coefficient is C(k,n) = round(2048·a_k·cos((2n+1)kπ/16)), with a_0 = sqrt(1/8) and a_k = 1/2 otherwise. sat16 limits the result to -32768..32767.
- R4: Column pass: p[y][n] = clip((T + 1024) >>> 11) to -256..255, where T = sum over u of C(u,y)·r[u][n]. p[y][n] is returned sign-extended in bits [16n+15:16n] of result row y.
- R5: For each of the first seven rows of a block, `wr_ready` is 0 for exactly 9 cycles after the row is accepted and then returns to 1.
- R6: Processing needs no command. `out_valid` rises exactly 90 cycles after the rising edge that accepts the eighth row.
- R7: Result rows come out in order y = 0..7, one per handshake. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R8: From the acceptance of the eighth row until the last result row is taken, `wr_ready` is 0, and writes offered in that time have no effect on any result.
- R9: After the eighth result handshake, `out_valid` drops to 0 and `wr_ready` is 1 in the next cycle, ready for a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Row write offered |
| wr_ready | output | 1 | Block can take a row this cycle |
| wr_data | input | 128 | Eight signed 16-bit coefficients |
| out_ready | input | 1 | Host requests/accepts a result row |
| out_valid | output | 1 | Result row available |
| out_data | output | 128 | Eight sign-extended 9-bit pixels |

## Verification
On every cycle the assertions check the handshake rules: the input is shut while results are pending, an accepted row makes `wr_ready` drop, a stalled result row holds its value, `out_valid` falls after the eighth read, and every returned field stays inside the pixel range. A counter in the checker also pins the 90-cycle latency from the eighth write. The arithmetic itself is shown only by the bench's scenarios. These compare each result row with a floating-point-derived reference for zero, single-coefficient, saturating, sparse and dense random blocks. The bench also shows that writes offered during a pending block leave both that block and the next one untouched.

// File: rtl/idct_pkg.sv
package idct_pkg;

  localparam int PTS    = 8;
  localparam int SMP_W  = 16;
  localparam int COEF_W = 12;
  localparam int FRAC_W = 11;
  localparam int PROD_W = SMP_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(PTS);
  localparam int ROW_W  = PTS * SMP_W;
  localparam int IDX_W  = $clog2(PTS);

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic [IDX_W-1:0]         idx_t;
  typedef logic [IDX_W:0]           ph_t;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_COL  = 2'd1,
    ST_PRE  = 2'd2,
    ST_OUT  = 2'd3
  } st_t;

  // Basis weight for frequency k at sample n, scaled by 2^FRAC_W.
  // Uses cosine symmetry so only nine magnitudes are listed.
  function automatic coef_t cos_coef(input idx_t k, input idx_t n);
    int m;
    int mag;
    logic neg;
    if (k == '0) return coef_t'(724);
    m = ((2 * int'(n) + 1) * int'(k)) % 32;
    if (m > 16) m = 32 - m;
    neg = (m > 8);
    if (neg) m = 16 - m;
    case (m)
      0:       mag = 1024;
      1:       mag = 1004;
      2:       mag = 946;
      3:       mag = 851;
      4:       mag = 724;
      5:       mag = 569;
      6:       mag = 392;
      7:       mag = 200;
      default: mag = 0;
    endcase
    return neg ? coef_t'(-mag) : coef_t'(mag);
  endfunction

endpackage

// File: rtl/idct_mac_lane.sv
module idct_mac_lane
  import idct_pkg::*;
(
  input  logic  clk,
  input  logic  en,
  input  logic  first,
  input  coef_t coef,
  input  smp_t  din,
  output acc_t  acc
);

  logic signed [PROD_W-1:0] prod;

  assign prod = din * coef;

  always_ff @(posedge clk) begin
    if (en) begin
      if (first) acc <= acc_t'(prod);
      else       acc <= acc + acc_t'(prod);
    end
  end

endmodule

// File: rtl/idct_mac_array.sv
module idct_mac_array
  import idct_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic  clk,
  input  logic  en,
  input  logic  first,
  input  coef_t coef [LANES],
  input  smp_t  din  [LANES],
  output acc_t  acc  [LANES]
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    idct_mac_lane u_lane (
      .clk   (clk),
      .en    (en),
      .first (first),
      .coef  (coef[i]),
      .din   (din[i]),
      .acc   (acc[i])
    );
  end

endmodule

// File: rtl/idct_round_pack.sv
module idct_round_pack
  import idct_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LO    = -32768,
  parameter int HI    = 32767
) (
  input  acc_t              acc [LANES],
  output logic [LANES*SMP_W-1:0] row
);

  localparam acc_t HALF = acc_t'(1) <<< (FRAC_W - 1);
  localparam acc_t LIM_HI = acc_t'(HI);
  localparam acc_t LIM_LO = acc_t'(LO);

  for (genvar i = 0; i < LANES; i++) begin : g_rnd
    acc_t t;
    acc_t c;
    always_comb begin
      t = (acc[i] + HALF) >>> FRAC_W;
      if (t > LIM_HI)      c = LIM_HI;
      else if (t < LIM_LO) c = LIM_LO;
      else                 c = t;
    end
    assign row[i*SMP_W +: SMP_W] = smp_t'(c);
  end

endmodule

// File: rtl/idct8_accel.sv
module idct8_accel
  import idct_pkg::*;
#(
  parameter int PIX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [ROW_W-1:0] wr_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [ROW_W-1:0] out_data
);

  localparam int  PIX_HI  = (1 <<< (PIX_W - 1)) - 1;
  localparam int  PIX_LO  = -(1 <<< (PIX_W - 1));
  localparam int  SAT_HI  = (1 <<< (SMP_W - 1)) - 1;
  localparam int  SAT_LO  = -(1 <<< (SMP_W - 1));
  localparam ph_t PH_WB   = ph_t'(PTS);
  localparam ph_t CS_WB   = ph_t'(PTS + 1);
  localparam idx_t IDX_LAST = idx_t'(PTS - 1);

  st_t  state;

  // ---------------- row pass ----------------
  logic             rbusy;
  ph_t              rphase;
  idx_t             row_idx;
  smp_t             xreg [PTS];
  logic             wr_fire;
  logic             row_wb;
  logic             row_en;
  logic             row_first;
  idx_t             row_k;
  coef_t            row_coef [PTS];
  smp_t             row_din  [PTS];
  acc_t             row_acc  [PTS];
  logic [ROW_W-1:0] row_res;

  assign wr_ready  = (state == ST_LOAD) && !rbusy;
  assign wr_fire   = wr_valid && wr_ready;
  assign row_wb    = rbusy && (rphase == PH_WB);
  assign row_en    = rbusy && (rphase < PH_WB);
  assign row_first = (rphase == '0);
  assign row_k     = rphase[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbusy   <= 1'b0;
      rphase  <= '0;
      row_idx <= '0;
    end else if (wr_fire) begin
      rbusy  <= 1'b1;
      rphase <= '0;
    end else if (rbusy) begin
      if (row_wb) begin
        rbusy   <= 1'b0;
        row_idx <= row_idx + idx_t'(1);
      end else begin
        rphase <= rphase + ph_t'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int i = 0; i < PTS; i++) xreg[i] <= wr_data[i*SMP_W +: SMP_W];
    end
  end

  for (genvar n = 0; n < PTS; n++) begin : g_row_in
    assign row_coef[n] = cos_coef(row_k, idx_t'(n));
    assign row_din[n]  = xreg[row_k];
  end

  idct_mac_array #(.LANES(PTS)) u_row_mac (
    .clk   (clk),
    .en    (row_en),
    .first (row_first),
    .coef  (row_coef),
    .din   (row_din),
    .acc   (row_acc)
  );

  idct_round_pack #(.LANES(PTS), .LO(SAT_LO), .HI(SAT_HI)) u_row_rnd (
    .acc (row_acc),
    .row (row_res)
  );

  // ---------------- transpose store ----------------
  logic [ROW_W-1:0] tmem [PTS];
  logic [ROW_W-1:0] tmem_q;
  ph_t              col_s;
  idx_t             col_y;

  always_ff @(posedge clk) begin
    if (row_wb) tmem[row_idx] <= row_res;
  end

  always_ff @(posedge clk) begin
    tmem_q <= tmem[col_s[IDX_W-1:0]];
  end

  // ---------------- column pass ----------------
  logic             col_en;
  logic             col_first;
  logic             col_wb;
  idx_t             col_u;
  coef_t            col_coef [PTS];
  smp_t             col_din  [PTS];
  acc_t             col_acc  [PTS];
  logic [ROW_W-1:0] col_res;

  assign col_en    = (state == ST_COL) && (col_s != '0) && (col_s <= PH_WB);
  assign col_first = (col_s == ph_t'(1));
  assign col_wb    = (state == ST_COL) && (col_s == CS_WB);
  assign col_u     = idx_t'(col_s - ph_t'(1));

  for (genvar n = 0; n < PTS; n++) begin : g_col_in
    assign col_coef[n] = cos_coef(col_u, col_y);
    assign col_din[n]  = tmem_q[n*SMP_W +: SMP_W];
  end

  idct_mac_array #(.LANES(PTS)) u_col_mac (
    .clk   (clk),
    .en    (col_en),
    .first (col_first),
    .coef  (col_coef),
    .din   (col_din),
    .acc   (col_acc)
  );

  idct_round_pack #(.LANES(PTS), .LO(PIX_LO), .HI(PIX_HI)) u_col_rnd (
    .acc (col_acc),
    .row (col_res)
  );

  // ---------------- output store and sequencing ----------------
  logic [ROW_W-1:0] omem [PTS];
  idx_t             oidx;
  logic             out_fire;

  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (col_wb) omem[col_y] <= col_res;
  end

  always_ff @(posedge clk) begin
    if (state == ST_PRE)
      out_data <= omem[0];
    else if (state == ST_OUT && out_fire && oidx != IDX_LAST)
      out_data <= omem[oidx + idx_t'(1)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOAD;
      col_s     <= '0;
      col_y     <= '0;
      oidx      <= '0;
      out_valid <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (row_wb && row_idx == IDX_LAST) begin
            state <= ST_COL;
            col_s <= '0;
            col_y <= '0;
          end
        end
        ST_COL: begin
          if (col_s == CS_WB) begin
            col_s <= '0;
            if (col_y == IDX_LAST) state <= ST_PRE;
            else                   col_y <= col_y + idx_t'(1);
          end else begin
            col_s <= col_s + ph_t'(1);
          end
        end
        ST_PRE: begin
          out_valid <= 1'b1;
          oidx      <= '0;
          state     <= ST_OUT;
        end
        default: begin
          if (out_fire) begin
            if (oidx == IDX_LAST) begin
              out_valid <= 1'b0;
              state     <= ST_LOAD;
            end else begin
              oidx <= oidx + idx_t'(1);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/idct8_accel_chk.sv
module idct8_accel_chk
  import idct_pkg::*;
#(
  parameter int PIX_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [ROW_W-1:0] wr_data,
  input logic             out_ready,
  input logic             out_valid,
  input logic [ROW_W-1:0] out_data
);

  localparam logic [7:0] LAT = 8'd90;

  logic [IDX_W-1:0] wcnt;
  logic [IDX_W-1:0] rcnt;
  logic [7:0]       tmr;
  logic             run;
  logic             wfire;
  logic             rfire;

  assign wfire = wr_valid && wr_ready;
  assign rfire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      rcnt <= '0;
      tmr  <= '0;
      run  <= 1'b0;
    end else begin
      if (wfire) wcnt <= wcnt + 1'b1;
      if (rfire) rcnt <= rcnt + 1'b1;
      if (wfire && wcnt == '1) begin
        run <= 1'b1;
        tmr <= '0;
      end else if (run) begin
        if (out_valid) run <= 1'b0;
        else           tmr <= tmr + 8'd1;
      end
    end
  end

  function automatic logic in_range(input logic [ROW_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PTS; i++) begin
      if ($signed(d[i*SMP_W +: SMP_W]) > $signed(SMP_W'((1 <<< (PIX_W - 1)) - 1)) ||
          $signed(d[i*SMP_W +: SMP_W]) < $signed(SMP_W'(-(1 <<< (PIX_W - 1)))))
        ok = 1'b0;
    end
    return ok;
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && wr_ready));

  // R5
  row_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wfire |=> !wr_ready);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (tmr == LAT));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !wr_ready);

  // R9
  last_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rfire && rcnt == '1) |=> (!out_valid && wr_ready));

  // R4
  pix_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_range(out_data));

endmodule

bind idct8_accel idct8_accel_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_idct8_accel.sv
`timescale 1ns/1ps
module tb_idct8_accel;

  localparam real PI = 3.14159265358979;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [127:0] wr_data = '0;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  int           xin [8][8];
  logic [127:0] exp_rows [8];

  always #4 clk = ~clk;

  idct8_accel dut (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int cf(int k, int n);
    real a;
    real v;
    a = (k == 0) ? $sqrt(0.125) : 0.5;
    v = 2048.0 * a * $cos(real'((2 * n + 1) * k) * PI / 16.0);
    if (v >= 0.0) return int'($floor(v + 0.5));
    return -int'($floor(-v + 0.5));
  endfunction

  // Reference transform following R3 and R4.
  function automatic void compute_exp();
    longint r [8][8];
    longint s;
    for (int u = 0; u < 8; u++)
      for (int n = 0; n < 8; n++) begin
        s = 0;
        for (int k = 0; k < 8; k++) s += longint'(cf(k, n)) * longint'(xin[u][k]);
        s = (s + 1024) >>> 11;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r[u][n] = s;
      end
    for (int y = 0; y < 8; y++)
      for (int n = 0; n < 8; n++) begin
        s = 0;
        for (int u = 0; u < 8; u++) s += longint'(cf(u, y)) * r[u][n];
        s = (s + 1024) >>> 11;
        if (s > 255) s = 255;
        if (s < -256) s = -256;
        exp_rows[y][n*16 +: 16] = 16'(s);
      end
  endfunction

  function automatic logic [127:0] pack_row(int u);
    logic [127:0] d;
    for (int i = 0; i < 8; i++) d[i*16 +: 16] = 16'(xin[u][i]);
    return d;
  endfunction

  task automatic send_row(input int u, input bit last);
    int lo;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = pack_row(u);
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = {8{16'hdead}};
    lo = 0;
    if (!last) begin
      while (!wr_ready && lo < 60) begin lo++; @(negedge clk); end
      check(lo == 9, "R5", $sformatf("busy cycles after row %0d", u), 128'(lo), 128'(9));
    end else begin
      while (!out_valid && lo < 300) begin
        check(!wr_ready, "R8", "wr_ready while computing", 128'(wr_ready), 128'(0));
        lo++;
        @(negedge clk);
      end
      check(lo == 90, "R6", "cycles from last row to out_valid", 128'(lo), 128'(90));
    end
  endtask

  task automatic run_block(input string name, input bit stall, input bit junk);
    logic [127:0] held;
    compute_exp();
    for (int u = 0; u < 8; u++) send_row(u, u == 7);
    if (junk) begin
      for (int j = 0; j < 3; j++) begin
        wr_valid = 1'b1;
        wr_data  = {8{16'h07ff}};
        check(!wr_ready, "R8", {name, " write offered while pending"}, 128'(wr_ready), 128'(0));
        @(negedge clk);
      end
      wr_valid = 1'b0;
    end
    for (int y = 0; y < 8; y++) begin
      if (stall && y == 3) begin
        out_ready = 1'b0;
        held = out_data;
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          check(out_valid && out_data == held, "R7", {name, " stalled row held"},
                out_data, held);
        end
      end
      out_ready = 1'b1;
      check(out_valid, "R7", {name, " valid during read"}, 128'(out_valid), 128'(1));
      check(out_data == exp_rows[y], "R3 R4",
            $sformatf("%s result row %0d", name, y), out_data, exp_rows[y]);
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(!out_valid && wr_ready, "R9", {name, " state after last read"},
          128'({out_valid, wr_ready}), 128'(2'b01));
  endtask

  task automatic fill(input int mode);
    for (int u = 0; u < 8; u++)
      for (int k = 0; k < 8; k++) begin
        case (mode)
          0: xin[u][k] = 0;
          1: xin[u][k] = (u == 0 && k == 0) ? 2047 : 0;
          2: xin[u][k] = (u == 0 && k == 0) ? -2048 : 0;
          3: xin[u][k] = ((u + k) % 2 == 0) ? 2047 : -2048;
          4: xin[u][k] = ($urandom_range(3) == 0) ? int'($urandom_range(4095)) - 2048 : 0;
          default: xin[u][k] = int'($urandom_range(4095)) - 2048;
        endcase
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R6 actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && wr_ready, "R1", "reset state",
          128'({out_valid, wr_ready}), 128'(2'b01));

    // R2 R3 R4 directed patterns
    fill(0); run_block("zero", 1'b0, 1'b0);
    fill(1); run_block("dc_pos", 1'b0, 1'b0);
    fill(2); run_block("dc_neg", 1'b1, 1'b0);
    fill(3); run_block("clip", 1'b0, 1'b1);
    // R8: the block after ignored writes must still be exact
    fill(1); run_block("after_junk", 1'b0, 1'b0);
    for (int b = 0; b < 6; b++) begin
      fill((b % 2 == 0) ? 4 : 5);
      run_block($sformatf("rand%0d", b), b == 3, b == 4);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule